// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor

A purely combinational adder-subtractor for two W-bit operands. Its carries do not ripple from bit to bit. Each bit position forms a generate and a propagate term. Four-bit groups expand every internal carry directly from those terms and the group's incoming carry. Each group also reports a group generate and a group propagate. A second lookahead stage combines these group terms with the initial carry to produce the carry into every group at once.

A mode input picks addition or subtraction. Subtraction inverts every bit of the second operand and forces the initial carry to one, which gives A minus B in two's complement. In add mode an external carry input supplies the initial carry. The outputs are the W-bit result, the raw carry out of the top bit, and a signed overflow flag.

Top module: `addsub_cla`

## Requirements
- R1: With `sub_en`=0, `result` equals (`op_a` + `op_b` + `carry_in`) modulo 2^W.
- R2: With `sub_en`=0, `carry_out` equals bit W of the (W+1)-bit sum `op_a` + `op_b` + `carry_in`.
- R3: With `sub_en`=1, `result` equals (`op_a` − `op_b`) modulo 2^W.
- R4: With `sub_en`=1, `carry_out` is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers, meaning no borrow occurred.
- R5: `ovf` is 1 exactly when the operation, with operands read as signed two's-complement values, has a true result outside the range −2^(W−1) to 2^(W−1)−1.
- R6: Within a 4-bit group, the group generate and the group propagate are never both 1. A group that propagates on every bit passes its incoming carry through unchanged.
- R7: The carry into each group equals the carry produced by the full lower-order part of the sum, including chains that run through every group.
- R8: With `sub_en`=1, `carry_in` has no effect on any output.
- R9: W must be a multiple of 4. With the default W=16 there are four groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub_en | input | 1 | 0 = add, 1 = subtract (op_a − op_b) |
| carry_in | input | 1 | Initial carry, used in add mode only |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Signed two's-complement overflow |

## Verification
The embedded assertions are evaluated whenever the inputs are known. They check the following: the result against the native add or subtract operator; the overflow flag against the operand and result sign bits; that group generate and group propagate are mutually exclusive; and that each expanded group carry agrees with the single-step recurrence from the carry below it. Some behaviour only shows at the ports, and only the bench's scenarios exercise it. This covers carry_out as a no-borrow flag, carry_in having no effect in subtract mode, and full-length carry chains such as all-ones plus one. The bench also compares random operands against its own reference model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int GRP_W = 4;

  // Carry into bit position idx (1..4) of a group, expanded as a sum of products
  function automatic logic la_carry4(input logic [3:0] g, input logic [3:0] p,
                                     input logic cin, input int idx);
    logic acc;
    logic term;
    term = cin;
    for (int m = 0; m < 4; m++) if (m < idx) term = term & p[m];
    acc = term;
    for (int j = 0; j < 4; j++) begin
      if (j < idx) begin
        term = g[j];
        for (int m = 0; m < 4; m++) if (m > j && m < idx) term = term & p[m];
        acc = acc | term;
      end
    end
    return acc;
  endfunction

  function automatic logic grp_generate(input logic [3:0] g, input logic [3:0] p);
    return la_carry4(g, p, 1'b0, 4);
  endfunction

  function automatic logic grp_propagate(input logic [3:0] p);
    return &p;
  endfunction
endpackage

// File: rtl/addsub_bitgp.sv
module addsub_bitgp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  assign gen  = a_in & b_in;
  assign prop = a_in ^ b_in;
endmodule

// File: rtl/addsub_group4.sv
module addsub_group4
  import addsub_pkg::*;
(
  input  logic [3:0] gen,
  input  logic [3:0] prop,
  input  logic       cin,
  output logic [3:0] cbits,
  output logic       grp_g,
  output logic       grp_p
);
  logic c1, c2, c3;

  assign c1    = la_carry4(gen, prop, cin, 1);
  assign c2    = la_carry4(gen, prop, cin, 2);
  assign c3    = la_carry4(gen, prop, cin, 3);
  assign cbits = {c3, c2, c1, cin};
  assign grp_g = grp_generate(gen, prop);
  assign grp_p = grp_propagate(prop);

  always_comb begin
    if (!$isunknown({gen, prop, cin})) begin
      p_gp_excl_r6: assert (!(grp_g && grp_p))
        else $error("R6: group generate and propagate both set");
      p_pass_r6: assert (!grp_p || (c3 == cin))
        else $error("R6: propagating group did not pass carry");
    end
  end
endmodule

// File: rtl/addsub_lookahead2.sv
module addsub_lookahead2 #(
  parameter int NG = 4
) (
  input  logic [NG-1:0] gg,
  input  logic [NG-1:0] gp,
  input  logic          c0,
  output logic [NG:0]   gc
);
  assign gc[0] = c0;

  for (genvar k = 0; k < NG; k++) begin : g_lvl
    logic carry_k;
    always_comb begin
      logic term;
      term = c0;
      for (int m = 0; m <= k; m++) term = term & gp[m];
      carry_k = term;
      for (int j = 0; j <= k; j++) begin
        term = gg[j];
        for (int m = j + 1; m <= k; m++) term = term & gp[m];
        carry_k = carry_k | term;
      end
    end
    assign gc[k+1] = carry_k;

    always_comb begin
      if (!$isunknown({gg, gp, c0})) begin
        p_gcarry_r7: assert (gc[k+1] == (gg[k] | (gp[k] & gc[k])))
          else $error("R7: expanded group carry disagrees with recurrence");
      end
    end
  end
endmodule

// File: rtl/addsub_cla.sv
module addsub_cla
  import addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_en,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf
);
  localparam int NG = W / GRP_W;

  if (W % GRP_W != 0 || W < GRP_W) begin : g_bad_width
    initial $error("R9: width must be a positive multiple of 4");
  end

  logic [W-1:0]  b_eff;
  logic          c0;
  logic [W-1:0]  gen, prop;
  logic [NG-1:0] gg, gp;
  logic [NG:0]   gc;
  logic [W:0]    cbit;

  assign b_eff = op_b ^ {W{sub_en}};
  assign c0    = sub_en | carry_in;

  addsub_bitgp #(.W(W)) u_bits (
    .a_in(op_a), .b_in(b_eff), .gen(gen), .prop(prop)
  );

  for (genvar k = 0; k < NG; k++) begin : g_grp
    addsub_group4 u_grp (
      .gen  (gen[k*GRP_W +: GRP_W]),
      .prop (prop[k*GRP_W +: GRP_W]),
      .cin  (gc[k]),
      .cbits(cbit[k*GRP_W +: GRP_W]),
      .grp_g(gg[k]),
      .grp_p(gp[k])
    );
  end

  addsub_lookahead2 #(.NG(NG)) u_la2 (
    .gg(gg), .gp(gp), .c0(c0), .gc(gc)
  );

  assign cbit[W]   = gc[NG];
  assign result    = prop ^ cbit[W-1:0];
  assign carry_out = cbit[W];
  assign ovf       = cbit[W] ^ cbit[W-1];

  always_comb begin
    if (!$isunknown({op_a, op_b, sub_en, carry_in})) begin
      if (!sub_en) begin
        p_add_r1: assert ({carry_out, result} ==
                          ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in}))
          else $error("R1: sum mismatch");
      end else begin
        p_sub_r3: assert (result == W'(op_a - op_b))
          else $error("R3: difference mismatch");
      end
      p_no_overflow_r5: assert (ovf == ((op_a[W-1] == b_eff[W-1]) &&
                                        (result[W-1] != op_a[W-1])))
        else $error("R5: overflow flag mismatch");
    end
  end
endmodule

// File: tb/sim_addsub_cla.sv
module sim_addsub_cla;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic sub_en, carry_in, carry_out, ovf;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  addsub_cla #(.W(W)) u0 (
    .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .ovf(ovf)
  );

  function automatic logic [W:0] ref_wide(logic [W-1:0] a, logic [W-1:0] b,
                                          logic s, logic ci);
    if (s) return {1'b0, a} - {1'b0, b} + (W+1)'(1 << W);
    return {1'b0, a} + {1'b0, b} + (W+1)'(ci);
  endfunction

  function automatic logic ref_ovf(logic [W-1:0] a, logic [W-1:0] b,
                                   logic s, logic ci);
    longint sa, sb, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = s ? (sa - sb) : (sa + sb + longint'(ci));
    return (r > ((64'sd1 <<< (W-1)) - 1)) || (r < -(64'sd1 <<< (W-1)));
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h sub=%b ci=%b)",
               tag, act, exp, op_a, op_b, sub_en, carry_in);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic s, logic ci,
                       string tag);
    logic [W:0] w;
    @(posedge clk);
    op_a = a; op_b = b; sub_en = s; carry_in = ci;
    @(negedge clk);
    w = ref_wide(a, b, s, ci);
    check({tag, s ? " R3 result" : " R1 result"}, {1'b0, result}, {1'b0, w[W-1:0]});
    if (s) check({tag, " R4 carry_out"}, {{W{1'b0}}, carry_out}, {{W{1'b0}}, (a >= b)});
    else   check({tag, " R2 carry_out"}, {{W{1'b0}}, carry_out}, {{W{1'b0}}, w[W]});
    check({tag, " R5 ovf"}, {{W{1'b0}}, ovf}, {{W{1'b0}}, ref_ovf(a, b, s, ci)});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r0;
    logic c0v, o0;
    void'($urandom(32'd1234));
    op_a = '0; op_b = '0; sub_en = 1'b0; carry_in = 1'b0;
    @(negedge clk);
    check("idle R1", {1'b0, result}, '0);
    check("idle R2", {{W{1'b0}}, carry_out}, '0);

    // R7 full-length chains through every group; R6 all-propagate groups
    apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R7 chain all groups");
    apply(16'h0FFF, 16'h0001, 1'b0, 1'b0, "R7 chain to top group");
    apply(16'hAAAA, 16'h5555, 1'b0, 1'b0, "R6 all propagate no cin");
    apply(16'hAAAA, 16'h5555, 1'b0, 1'b1, "R6 all propagate cin");
    apply(16'h00F0, 16'h0010, 1'b0, 1'b0, "R7 group boundary");
    // R5 signed edges
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R5 pos ovf add");
    apply(16'h8000, 16'h8000, 1'b0, 1'b0, "R5 neg ovf add");
    apply(16'h8000, 16'h0001, 1'b1, 1'b0, "R5 neg ovf sub");
    apply(16'h7FFF, 16'hFFFF, 1'b1, 1'b0, "R5 pos ovf sub");
    // R4 borrow edges
    apply(16'h1234, 16'h1234, 1'b1, 1'b0, "R4 equal");
    apply(16'h0000, 16'h0001, 1'b1, 1'b0, "R4 borrow");
    apply(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R4 max minus zero");

    // R8 carry_in has no effect in subtract mode
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      apply(a, b, 1'b1, 1'b0, "R8 base");
      r0 = result; c0v = carry_out; o0 = ovf;
      apply(a, b, 1'b1, 1'b1, "R8 cin set");
      check("R8 result unchanged", {1'b0, result}, {1'b0, r0});
      check("R8 carry_out unchanged", {{W{1'b0}}, carry_out}, {{W{1'b0}}, c0v});
      check("R8 ovf unchanged", {{W{1'b0}}, ovf}, {{W{1'b0}}, o0});
    end

    // R9 default width: four groups, top group carry reaches carry_out
    apply(16'hF000, 16'h1000, 1'b0, 1'b0, "R9 top group");

    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom), "random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule